// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block watches a small set of external interrupt pins and turns each one into an interrupt request according to a per-pin trigger setting. Each pin can be set to trigger on a high level, a low level, a rising edge, a falling edge or on any edge. Edge events are held in a sticky flag until software acknowledges them by writing a one to that pin's acknowledge bit. A per-pin enable bit gates the request. Every pin first passes through a two-stage synchroniser.

Settings are held in 32-bit control words, one word per group of four pins. Pin `p` uses word `p / 4` and slot `p % 4` inside that word. The default build has four pins and one word. Setting `NUM_PINS` to 6 adds a second word, whose slots 0 and 1 serve pins 4 and 5. A write replaces the whole addressed word. A read returns the stored settings of the addressed word.

Top module: `ext_trig_unit`

## Requirements
- R1: After reset, every control word reads as zero, which selects falling-edge mode with the enable off, and `irq_req` is all zero.
- R2: Within a control word, slot `s` uses these bits: `s` is write-one acknowledge, `4+s` is polarity, `8+s` is any-edge, `12+s` is level-select and `16+s` is enable. Acknowledge bits, bits 31..20 and slots with no pin behind them all read back as 0.
- R3: Pin `p` is governed only by slot `p % 4` of word `p / 4`. A word-1 setting drives pins 4 and 5 and never a pin of word 0.
- R4: With any-edge=0, level-select=1 and polarity=1, the request equals the pin value with no latching. It follows a pin change at the second clock edge after the change.
- R5: With any-edge=0, level-select=1 and polarity=0, the request equals the inverted pin value, with the same two-edge latency as R4.
- R6: With all of any-edge, level-select and polarity-dependent bits set so that any-edge=0, level-select=0 and polarity=1, a rising pin sets the held event at the third clock edge after the change. A falling pin does not set it.
- R7: With any-edge, level-select and polarity all 0, a falling pin sets the held event at the third clock edge after the change. A rising pin does not set it.
- R8: With any-edge=1, either pin transition sets the held event, whatever the level-select and polarity bits are.
- R9: A pin with enable 0 never raises its request. An edge event that arrives while the pin is disabled is still held, so it appears on the request as soon as the enable is written to 1.
- R10: A write with acknowledge bit `s` set clears the held event of that slot at that clock edge. The acknowledge bit of any other slot leaves the event in place.
- R11: If an acknowledge and a new qualifying edge reach a pin in the same cycle, the event stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| cfg_wr_en | input | 1 | Write strobe for one control word |
| cfg_wr_bank | input | BANK_W | Index of the word to write |
| cfg_wr_data | input | 32 | Write data, with acknowledge bits acting as one-cycle pulses |
| cfg_rd_bank | input | BANK_W | Index of the word to read |
| cfg_rd_data | output | 32 | Combinational readback of the addressed word |
| irq_req | output | NUM_PINS | Per-pin interrupt request |

## Verification
The bench is built with six pins, so both control words are used. For every pin, it tries all eight combinations of the three trigger bits with both a rising and a falling transition. It samples the request one edge after the synchronised pin settles and again one edge later. The early sample separates the level modes from the edge modes, because only the level modes respond at that point. The late sample shows which transitions each edge mode latches, and that any-edge overrides the polarity bit. Directed sequences then cover readback masking, a slot acknowledged in a word that holds another slot's event, an event that arrives while the pin is disabled, and an acknowledge that collides with a fresh edge.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

    localparam int SLOTS_PER_WORD = 4;
    localparam int WORD_W         = 32;

    localparam int ACK_LSB   = 0;
    localparam int POL_LSB   = 4;
    localparam int ANY_LSB   = 8;
    localparam int LVL_LSB   = 12;
    localparam int EN_LSB    = 16;

    typedef struct packed {
        logic lvl_sel;
        logic pol;
        logic any_edge;
        logic en;
    } lane_cfg_t;

    typedef enum logic [2:0] {
        TRIG_FALL   = 3'd0,
        TRIG_RISE   = 3'd1,
        TRIG_ANY    = 3'd2,
        TRIG_LVL_LO = 3'd3,
        TRIG_LVL_HI = 3'd4
    } trig_mode_t;

    function automatic trig_mode_t decode_mode(input lane_cfg_t c);
        trig_mode_t m;
        if (c.any_edge)     m = TRIG_ANY;
        else if (c.lvl_sel) m = c.pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        else                m = c.pol ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

    function automatic lane_cfg_t slot_from_word(input logic [WORD_W-1:0] w,
                                                 input int slot);
        lane_cfg_t c;
        c.lvl_sel  = w[LVL_LSB + slot];
        c.pol      = w[POL_LSB + slot];
        c.any_edge = w[ANY_LSB + slot];
        c.en       = w[EN_LSB  + slot];
        return c;
    endfunction

endpackage

// File: rtl/ext_trig_sync.sv
module ext_trig_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/ext_trig_regs.sv
module ext_trig_regs
    import ext_trig_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int NUM_WORDS = 1,
    parameter int BANK_W = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [BANK_W-1:0]   wr_bank,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [BANK_W-1:0]   rd_bank,
    output logic [WORD_W-1:0]   rd_data,
    output lane_cfg_t           cfg   [NUM_PINS],
    output logic [NUM_PINS-1:0] ack
);
    lane_cfg_t cfg_q [NUM_PINS];
    logic      unused_wr;

    assign unused_wr = ^wr_data;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
        localparam int WI = i / SLOTS_PER_WORD;
        localparam int SI = i % SLOTS_PER_WORD;
        logic hit;

        assign hit    = wr_en && (int'(wr_bank) == WI);
        assign ack[i] = hit && wr_data[ACK_LSB + SI];
        assign cfg[i] = cfg_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (hit) begin
                cfg_q[i] <= slot_from_word(wr_data, SI);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (int'(rd_bank) == i / SLOTS_PER_WORD) begin
                rd_data[POL_LSB + i % SLOTS_PER_WORD] = cfg_q[i].pol;
                rd_data[ANY_LSB + i % SLOTS_PER_WORD] = cfg_q[i].any_edge;
                rd_data[LVL_LSB + i % SLOTS_PER_WORD] = cfg_q[i].lvl_sel;
                rd_data[EN_LSB  + i % SLOTS_PER_WORD] = cfg_q[i].en;
            end
        end
    end
endmodule

// File: rtl/ext_trig_lane.sv
module ext_trig_lane
    import ext_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t cfg,
    input  logic      ack,
    input  logic      cur,
    input  logic      prev,
    output logic      held,
    output logic      req
);
    trig_mode_t mode;
    logic       rise;
    logic       fall;
    logic       fire;
    logic       is_level;
    logic       lvl_val;
    logic       held_q;

    always_comb begin
        mode     = decode_mode(cfg);
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        is_level = 1'b0;
        lvl_val  = 1'b0;
        fire     = 1'b0;
        case (mode)
            TRIG_FALL:   fire = fall;
            TRIG_RISE:   fire = rise;
            TRIG_ANY:    fire = rise | fall;
            TRIG_LVL_HI: begin is_level = 1'b1; lvl_val = cur;  end
            TRIG_LVL_LO: begin is_level = 1'b1; lvl_val = ~cur; end
            default:     fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (fire) begin
            held_q <= 1'b1;
        end else if (ack) begin
            held_q <= 1'b0;
        end
    end

    assign held = held_q;
    assign req  = cfg.en & (is_level ? lvl_val : held_q);
endmodule

// File: rtl/ext_trig_unit.sv
module ext_trig_unit
    import ext_trig_pkg::*;
#(
    parameter int NUM_PINS  = 4,
    localparam int NUM_WORDS = (NUM_PINS + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD,
    localparam int BANK_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                cfg_wr_en,
    input  logic [BANK_W-1:0]   cfg_wr_bank,
    input  logic [31:0]         cfg_wr_data,
    input  logic [BANK_W-1:0]   cfg_rd_bank,
    output logic [31:0]         cfg_rd_data,
    output logic [NUM_PINS-1:0] irq_req
);
    lane_cfg_t           lane_cfg [NUM_PINS];
    logic [NUM_PINS-1:0] lane_ack;
    logic [NUM_PINS-1:0] pin_cur;
    logic [NUM_PINS-1:0] pin_prev;
    logic [NUM_PINS-1:0] lane_held;
    logic [NUM_PINS-1:0] lane_lvl;
    logic [NUM_PINS-1:0] lane_pol;
    logic [NUM_PINS-1:0] lane_any;
    logic [NUM_PINS-1:0] lane_en;

    ext_trig_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (pin_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    ext_trig_regs #(
        .NUM_PINS (NUM_PINS),
        .NUM_WORDS(NUM_WORDS),
        .BANK_W   (BANK_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_bank (cfg_wr_bank),
        .wr_data (cfg_wr_data),
        .rd_bank (cfg_rd_bank),
        .rd_data (cfg_rd_data),
        .cfg     (lane_cfg),
        .ack     (lane_ack)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        lane_cfg_t c;
        assign lane_lvl[i] = lane_cfg[i].lvl_sel;
        assign lane_pol[i] = lane_cfg[i].pol;
        assign lane_any[i] = lane_cfg[i].any_edge;
        assign lane_en[i]  = lane_cfg[i].en;
        assign c = '{lvl_sel: lane_lvl[i], pol: lane_pol[i],
                     any_edge: lane_any[i], en: lane_en[i]};

        ext_trig_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .cfg  (c),
            .ack  (lane_ack[i]),
            .cur  (pin_cur[i]),
            .prev (pin_prev[i]),
            .held (lane_held[i]),
            .req  (irq_req[i])
        );
    end
endmodule

// File: rtl/ext_trig_unit_chk.sv
module ext_trig_unit_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] lvl,
    input logic [NUM_PINS-1:0] pol,
    input logic [NUM_PINS-1:0] any,
    input logic [NUM_PINS-1:0] en,
    input logic [NUM_PINS-1:0] ack,
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] prev,
    input logic [NUM_PINS-1:0] held,
    input logic [NUM_PINS-1:0] req
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            !en[i] |-> !req[i]);

        assert_level_follows_R4: assert property (@(posedge clk) disable iff (rst)
            (lvl[i] && !any[i] && en[i]) |-> (req[i] == (pol[i] ? cur[i] : !cur[i])));

        assert_rise_latched_R6: assert property (@(posedge clk) disable iff (rst)
            (!lvl[i] && !any[i] && pol[i] && cur[i] && !prev[i]) |=> held[i]);

        assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
            (ack[i] && (cur[i] == prev[i])) |=> !held[i]);

        assert_edge_beats_ack_R11: assert property (@(posedge clk) disable iff (rst)
            (ack[i] && any[i] && (cur[i] != prev[i])) |=> held[i]);
    end
endmodule

bind ext_trig_unit ext_trig_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lane_lvl),
    .pol  (lane_pol),
    .any  (lane_any),
    .en   (lane_en),
    .ack  (lane_ack),
    .cur  (pin_cur),
    .prev (pin_prev),
    .held (lane_held),
    .req  (irq_req)
);

// File: tb/ext_trig_unit_tb.sv
`timescale 1ns/1ps
module ext_trig_unit_tb;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic          cfg_wr_en = 1'b0;
    logic [0:0]    cfg_wr_bank = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic [0:0]    cfg_rd_bank = '0;
    logic [31:0]   cfg_rd_data;
    logic [NP-1:0] irq_req;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    ext_trig_unit #(.NUM_PINS(NP)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .pin_in      (pin_in),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_bank (cfg_wr_bank),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_bank (cfg_rd_bank),
        .cfg_rd_data (cfg_rd_data),
        .irq_req     (irq_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input int bank, input logic [31:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_bank = 1'(bank);
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rd(input int bank, output logic [31:0] v);
        cfg_rd_bank = 1'(bank);
        #0.5;
        v = cfg_rd_data;
    endtask

    function automatic logic [31:0] slot_word(input int s, input bit lv, input bit po,
                                              input bit an, input bit e, input bit ak);
        logic [31:0] w = '0;
        w[s]      = ak;
        w[4 + s]  = po;
        w[8 + s]  = an;
        w[12 + s] = lv;
        w[16 + s] = e;
        return w;
    endfunction

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(0, v); chk("R1 word0", v, 32'h0);
        rd(1, v); chk("R1 word1", v, 32'h0);
        chk("R1 irq", 32'(irq_req), 32'h0);

        // R2 readback masking, R3 second word
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); chk("R2 word0 readback", v, 32'h000F_FFF0);
        wr(1, 32'hFFFF_FFFF);
        rd(1, v); chk("R3 word1 readback", v, 32'h0003_3330);
        wr(0, 32'h0); wr(1, 32'h0);
        step(4);

        // Sweep: every pin, every trigger code, both transitions
        for (int p = 0; p < NP; p++) begin
            for (int code = 0; code < 8; code++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    bit lv, po, an, endv, exp2, exp3, hit;
                    string tag;
                    int bank, s;
                    bank = p / 4; s = p % 4;
                    lv = code[2]; po = code[1]; an = code[0];
                    endv = (dir == 1);
                    pin_in = '0;
                    pin_in[p] = ~endv;
                    wr(1 - bank, 32'h0);
                    w = slot_word(s, lv, po, an, 1'b1, 1'b0);
                    wr(bank, w);
                    step(4);
                    wr(bank, w | (32'h1 << s));
                    pin_in[p] = endv;
                    if (an) begin
                        tag = "R8 any-edge"; exp2 = 1'b0; exp3 = 1'b1;
                    end else if (lv) begin
                        tag = po ? "R4 level-high" : "R5 level-low";
                        exp2 = po ? endv : ~endv; exp3 = exp2;
                    end else begin
                        hit = po ? endv : ~endv;
                        tag = po ? "R6 rising" : "R7 falling";
                        exp2 = 1'b0; exp3 = hit;
                    end
                    if (p >= 4) tag = {tag, " R3 word1"};
                    step(2);
                    chk(tag, 32'(irq_req), 32'(exp2) << p);
                    step(1);
                    chk(tag, 32'(irq_req), 32'(exp3) << p);
                end
            end
        end

        pin_in = '0;
        wr(1, 32'h0);
        wr(0, 32'h0);
        step(4);

        // R9 event held while disabled
        w = slot_word(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        wr(0, w);
        pin_in[0] = 1'b1;
        step(4);
        chk("R9 disabled", 32'(irq_req), 32'h0);
        w = slot_word(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        wr(0, w);
        chk("R9 enable shows held", 32'(irq_req), 32'h1);

        // R10 other slot ack leaves event, own ack clears
        wr(0, w | 32'h2);
        chk("R10 other ack", 32'(irq_req), 32'h1);
        wr(0, w | 32'h1);
        chk("R10 own ack", 32'(irq_req), 32'h0);

        // R11 ack and fresh edge in same cycle
        w = slot_word(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        wr(0, w);
        pin_in[0] = 1'b0;
        step(3);
        chk("R11 setup", 32'(irq_req), 32'h1);
        pin_in[0] = 1'b1;
        step(2);
        wr(0, w | 32'h1);
        chk("R11 edge beats ack", 32'(irq_req), 32'h1);
        wr(0, w | 32'h1);
        chk("R10 quiet ack", 32'(irq_req), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule